// File: doc/BRIEF.md
# Consumer IR receive front end

This block receives an already demodulated infrared remote-control signal and turns it into a stream of run-length bytes that software drains through a small register bus. The input passes through a two-flop synchronizer and is sampled once per sample period, which is the core clock divided by a programmable power of two. A glitch filter ignores any level that lasts fewer samples than a programmable threshold. The filtered waveform is encoded as bytes that hold a level and a run length in samples. These bytes go into a 64-entry receive FIFO.

A packet begins at the first filtered transition away from the resting state. It ends once the line has stayed free of transitions for a programmable number of 128-sample blocks. Three interrupt sources are each masked by an enable bit and combined onto one interrupt line: data available (FIFO fill at or above a trigger level), packet end, and FIFO overflow. The FIFO applies no back-pressure to the encoder. A byte that arrives while the FIFO is full is discarded and flagged as an overflow, so software must read the data register fast enough to keep up. Each read of the data register removes one byte.

Top module: `cir_rx_frontend`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The byte offsets are: control 0x00, input config 0x10, data 0x20, interrupt enable 0x2C, interrupt status 0x30, sample config 0x34.
- R2: The receiver runs only when control bits [1:0] are both 1 and control bits [5:4] are both 1. With any other control value, input activity produces no FIFO bytes and no status.
- R3: Sample config bits [1:0] = c sample the input once every 64·2^c core clocks. Sample config bits [7:2] = T set the glitch filter: the filtered level changes only after the new level has been seen on T consecutive samples (T=0 acts as 1). A shorter excursion counts as part of the surrounding run.
- R4: Each FIFO byte holds the filtered level in bit 7 and the run length in samples in bits [6:0]. A byte is written when the level changes. A run is also cut into a 127-sample byte each time it reaches 127 samples, and a zero-length remainder is never written.
- R5: The first filtered transition after an idle period starts a packet and writes no byte for the idle level that preceded it.
- R6: With sample config bits [15:8] = N, a packet ends after (N+1)·128 samples with no filtered transition following the last one. At that point status bit 1 is set and the unwritten part of the final run is dropped.
- R7: The FIFO holds 64 bytes. A byte produced while it is full is dropped and sets status bit 0, and the stored bytes keep their order.
- R8: A read of offset 0x20 returns the oldest byte in bits [7:0] and removes it. A read of an empty FIFO returns zero.
- R9: Status bit 4 reads 1 exactly while the FIFO fill is at least (enable register bits [13:8]) + 1.
- R10: Writing 1 to status bit 0 or bit 1 clears that bit. Writing 0 leaves it unchanged.
- R11: `irq` is high when any of status bits 0, 1 or 4 is set together with the enable register bit at the same position.
- R12: Leaving the running state empties the FIFO and resets the filter and the run counter.
- R13: Input config bit 0 inverts the synchronized input before filtering, so the line must idle low instead of high.
- R14: The sample config register reads back bits [23:0] as written, including the active-threshold field in bits [23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated IR line, asynchronous, idles high |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the expected byte stream from segment lists. In that stream a 300-sample run must come out as 127, 127 and 46, and a three-sample dip inside a mark must vanish into a single 16-sample byte. An encoder that miscounts at the split boundary, writes zero-length bytes or lets the glitch through gives a shifted or extra byte in the read-back. Pushing 70 runs into the 64-entry FIFO checks that the overflow flag is set and that the first 64 bytes survive in order; a design that overwrote old data or kept the wrong bytes would fail the drain. The bench also checks that data-available drops once the fill falls below the trigger, that write-one-to-clear leaves data-available untouched, and that disabling flushes the FIFO. It checks that a wrong control code leaves the receiver silent and that input inversion swaps the levels in bit 7.

// File: rtl/cir_rx_pkg.sv
`timescale 1ns/1ps
package cir_rx_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_INCFG = 8'h10;
  localparam logic [7:0] OFS_DATA  = 8'h20;
  localparam logic [7:0] OFS_IEN   = 8'h2C;
  localparam logic [7:0] OFS_IST   = 8'h30;
  localparam logic [7:0] OFS_SCFG  = 8'h34;

  localparam int BIT_OVF  = 0;
  localparam int BIT_PEND = 1;
  localparam int BIT_AVL  = 4;

  localparam int RUN_W   = 7;
  localparam int RUN_MAX = (1 << RUN_W) - 1;

  typedef struct packed {
    logic             level;
    logic [RUN_W-1:0] run;
  } run_byte_t;
endpackage

// File: rtl/cir_sample_filter.sv
`timescale 1ns/1ps
module cir_sample_filter #(
  parameter int DIV_BASE_LOG2 = 6,
  parameter int THR_W         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             invert,
  input  logic [1:0]       div_code,
  input  logic [THR_W-1:0] thr,
  input  logic             ir_raw,
  output logic             samp_tick,
  output logic             filt
);
  localparam int DIVW = DIV_BASE_LOG2 + 3;

  logic            sync_a, sync_b;
  logic [DIVW-1:0] div_cnt, div_lim;
  logic            tick_c;
  logic [THR_W-1:0] pend, thr_eff;
  logic            sample_lvl;

  // two-flop synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else begin
      sync_a <= ir_raw;
      sync_b <= sync_a;
    end
  end

  assign div_lim    = {DIVW{1'b1}} >> (2'd3 - div_code);
  assign tick_c     = active && (div_cnt == div_lim);
  assign sample_lvl = sync_b ^ invert;
  assign thr_eff    = (thr == '0) ? THR_W'(1) : thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (!active || tick_c) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      filt <= 1'b1;
    end else if (!active) begin
      pend <= '0;
      filt <= 1'b1;
    end else if (tick_c) begin
      if (sample_lvl == filt) begin
        pend <= '0;
      end else if ({1'b0, pend} + 1'b1 >= {1'b0, thr_eff}) begin
        filt <= ~filt;
        pend <= '0;
      end else begin
        pend <= pend + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_tick <= 1'b0;
    else        samp_tick <= tick_c;
  end

  // R3
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick_c) |=> $stable(filt));
endmodule

// File: rtl/cir_run_encoder.sv
`timescale 1ns/1ps
module cir_run_encoder
  import cir_rx_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              samp_tick,
  input  logic              filt,
  input  logic [IDLE_W-1:0] idle_thr,
  output logic              byte_valid,
  output run_byte_t         byte_data,
  output logic              pkt_end
);
  localparam int ICW = IDLE_W + 7;

  logic             cur_lvl, armed;
  logic [RUN_W-1:0] run;
  logic [ICW-1:0]   idle_cnt, idle_last;

  assign idle_last = {idle_thr, 7'h7F};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl    <= 1'b1;
      armed      <= 1'b0;
      run        <= '0;
      idle_cnt   <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      pkt_end    <= 1'b0;
    end else if (!active) begin
      cur_lvl    <= 1'b1;
      armed      <= 1'b0;
      run        <= '0;
      idle_cnt   <= '0;
      byte_valid <= 1'b0;
      pkt_end    <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      pkt_end    <= 1'b0;
      if (samp_tick) begin
        if (!armed) begin
          if (filt != cur_lvl) begin
            cur_lvl  <= filt;
            run      <= RUN_W'(1);
            armed    <= 1'b1;
            idle_cnt <= '0;
          end
        end else if (filt != cur_lvl) begin
          if (run != '0) begin
            byte_valid <= 1'b1;
            byte_data  <= '{level: cur_lvl, run: run};
          end
          cur_lvl  <= filt;
          run      <= RUN_W'(1);
          idle_cnt <= '0;
        end else begin
          if (run == RUN_W'(RUN_MAX - 1)) begin
            byte_valid <= 1'b1;
            byte_data  <= '{level: cur_lvl, run: RUN_W'(RUN_MAX)};
            run        <= '0;
          end else begin
            run <= run + 1'b1;
          end
          if (idle_cnt == idle_last) begin
            pkt_end  <= 1'b1;
            armed    <= 1'b0;
            run      <= '0;
            idle_cnt <= '0;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R4
  run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (byte_data.run != '0));

  // R5
  no_byte_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !armed) |=> !byte_valid);
endmodule

// File: rtl/cir_rx_fifo.sv
`timescale 1ns/1ps
module cir_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count)));
endmodule

// File: rtl/cir_rx_frontend.sv
`timescale 1ns/1ps
module cir_rx_frontend
  import cir_rx_pkg::*;
#(
  parameter int DIV_BASE_LOG2 = 6,
  parameter int FIFO_DEPTH    = 64,
  parameter int BUS_W         = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;
  localparam int LW = $clog2(FIFO_DEPTH);

  logic [1:0]  ctrl_en, ctrl_mode;
  logic        in_inv;
  logic [23:0] scfg;
  logic        ien_ovf, ien_pend, ien_avl;
  logic [LW-1:0] trig_m1;
  logic        st_ovf, st_pend;

  logic        active, samp_tick, filt, byte_valid, pkt_end;
  run_byte_t   byte_data;
  logic [7:0]  head;
  logic [CW-1:0] fill;
  logic        full, empty, avl, pop, wr_ist;

  assign active = (ctrl_en == 2'b11) && (ctrl_mode == 2'b11);
  assign pop    = bus_en && !bus_we && (bus_addr == OFS_DATA) && !empty;
  assign avl    = (fill >= ({1'b0, trig_m1} + 1'b1));
  assign wr_ist = bus_en && bus_we && (bus_addr == OFS_IST);
  assign irq    = (st_ovf && ien_ovf) || (st_pend && ien_pend) || (avl && ien_avl);

  cir_sample_filter #(.DIV_BASE_LOG2(DIV_BASE_LOG2), .THR_W(6)) u_filt (
    .clk, .rst_n, .active, .invert(in_inv), .div_code(scfg[1:0]),
    .thr(scfg[7:2]), .ir_raw(ir_in), .samp_tick, .filt
  );

  cir_run_encoder #(.IDLE_W(8)) u_enc (
    .clk, .rst_n, .active, .samp_tick, .filt, .idle_thr(scfg[15:8]),
    .byte_valid, .byte_data, .pkt_end
  );

  cir_rx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n, .flush(!active), .push(byte_valid), .wdata(byte_data),
    .pop, .rdata(head), .count(fill), .full, .empty
  );

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= '0;
      ctrl_mode <= '0;
      in_inv   <= 1'b0;
      scfg     <= '0;
      ien_ovf  <= 1'b0;
      ien_pend <= 1'b0;
      ien_avl  <= 1'b0;
      trig_m1  <= '0;
    end else if (bus_en && bus_we) begin
      case (bus_addr)
        OFS_CTRL: begin
          ctrl_en   <= bus_wdata[1:0];
          ctrl_mode <= bus_wdata[5:4];
        end
        OFS_INCFG: in_inv <= bus_wdata[0];
        OFS_SCFG:  scfg   <= bus_wdata[23:0];
        OFS_IEN: begin
          ien_ovf  <= bus_wdata[BIT_OVF];
          ien_pend <= bus_wdata[BIT_PEND];
          ien_avl  <= bus_wdata[BIT_AVL];
          trig_m1  <= bus_wdata[8 +: LW];
        end
        default: ;
      endcase
    end
  end

  // sticky status, set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ovf  <= 1'b0;
      st_pend <= 1'b0;
    end else begin
      if (byte_valid && full)                      st_ovf <= 1'b1;
      else if (wr_ist && bus_wdata[BIT_OVF])       st_ovf <= 1'b0;
      if (pkt_end)                                 st_pend <= 1'b1;
      else if (wr_ist && bus_wdata[BIT_PEND])      st_pend <= 1'b0;
    end
  end

  // registered read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      bus_rdata <= '0;
      case (bus_addr)
        OFS_CTRL:  bus_rdata[5:0] <= {ctrl_mode, 2'b00, ctrl_en};
        OFS_INCFG: bus_rdata[0]   <= in_inv;
        OFS_DATA:  bus_rdata[7:0] <= empty ? 8'h00 : head;
        OFS_IEN: begin
          bus_rdata[BIT_OVF]  <= ien_ovf;
          bus_rdata[BIT_PEND] <= ien_pend;
          bus_rdata[BIT_AVL]  <= ien_avl;
          bus_rdata[8 +: LW]  <= trig_m1;
        end
        OFS_IST: begin
          bus_rdata[BIT_OVF]  <= st_ovf;
          bus_rdata[BIT_PEND] <= st_pend;
          bus_rdata[BIT_AVL]  <= avl;
        end
        OFS_SCFG:  bus_rdata[23:0] <= scfg;
        default: ;
      endcase
    end
  end

  // R12
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (fill == '0));

  // R6
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pend) |-> $past(pkt_end));

  // R7
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovf) |-> $past(byte_valid && full));
endmodule

// File: tb/cir_rx_frontend_test.sv
`timescale 1ns/1ps
module cir_rx_frontend_test;
  localparam int SPC = 64;  // clocks per sample with divider code 0

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  cir_rx_frontend uut (
    .clk, .rst_n, .ir_in, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .irq
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [23:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = int'(bus_rdata);
  endtask

  task automatic seg(input logic lvl, input int n);
    @(negedge clk); ir_in = lvl;
    repeat (n * SPC - 1) @(negedge clk);
  endtask

  task automatic exp_run(input logic lvl, input int len);
    while (len > 127) begin expq.push_back({lvl, 7'd127}); len -= 127; end
    if (len > 0) expq.push_back({lvl, 7'(len)});
  endtask

  task automatic drain(input string tag, input int n);
    int v;
    for (int i = 0; i < n; i++) begin
      rd(8'h20, v);
      chk(tag, v, int'(expq.pop_front()));
    end
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h30, v); chk("R1 status", v, 0);
    rd(8'h34, v); chk("R1 scfg", v, 0);
    rd(8'h2C, v); chk("R1 ien", v, 0);
    chk("R1 irq", int'(irq), 0);

    // T=4, N=2, active threshold field 0x85
    wr(8'h34, 24'h850210);
    rd(8'h34, v); chk("R14 scfg readback", v, 24'h850210);
    wr(8'h2C, 24'h000313);

    // R2 enable bits only, mode bits clear: silent
    wr(8'h00, 24'h03);
    seg(0, 20); seg(1, 10);
    rd(8'h30, v); chk("R2 no status", v, 0);
    rd(8'h20, v); chk("R2 no data", v, 0);

    // main pattern with a glitch inside a mark
    wr(8'h00, 24'h33);
    repeat (10) @(negedge clk);
    seg(0, 20); seg(1, 5); seg(0, 3); seg(1, 8); seg(0, 300); seg(1, 400);
    exp_run(0, 20); exp_run(1, 16); exp_run(0, 300);
    repeat (3) expq.push_back(8'hFF);  // idle chunks before packet end
    rd(8'h30, v); chk("R6 R9 status after packet", v, 8'h12);
    chk("R11 irq asserted", int'(irq), 1);
    wr(8'h30, 24'h02);
    rd(8'h30, v); chk("R10 clear packet end only", v, 8'h10);
    chk("R11 irq from data avail", int'(irq), 1);
    wr(8'h2C, 24'h000300);
    chk("R11 irq masked", int'(irq), 0);
    wr(8'h2C, 24'h000313);
    drain("R3 R4 R5 byte", 5);
    rd(8'h30, v); chk("R9 below trigger", v, 0);
    drain("R4 R8 byte", 3);
    rd(8'h20, v); chk("R8 empty read", v, 0);

    // overflow: T=1, N=0, 70 two-sample runs
    wr(8'h00, 24'h00);
    wr(8'h34, 24'h000004);
    wr(8'h00, 24'h33);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 70; i++) seg(i[0], 2);
    seg(1, 140);
    for (int i = 0; i < 64; i++) expq.push_back(i[0] ? 8'h82 : 8'h02);
    rd(8'h30, v); chk("R7 overflow flag", v & 1, 1);
    drain("R7 kept byte", 64);
    rd(8'h20, v); chk("R7 R8 empty after 64", v, 0);
    wr(8'h30, 24'h03);
    rd(8'h30, v); chk("R10 clear both", v, 0);

    // R12 flush on disable
    for (int i = 0; i < 7; i++) seg(i[0], 2);
    seg(1, 4);
    rd(8'h30, v); chk("R12 data present", v & 8'h10, 8'h10);
    wr(8'h00, 24'h00);
    wr(8'h00, 24'h33);
    rd(8'h30, v); chk("R12 flushed status", v & 8'h10, 0);
    rd(8'h20, v); chk("R12 flushed data", v, 0);
    wr(8'h30, 24'h03);

    // R13 inverted input idling low
    wr(8'h00, 24'h00);
    wr(8'h10, 24'h01);
    rd(8'h10, v); chk("R13 incfg readback", v, 1);
    ir_in = 0;
    repeat (10) @(negedge clk);
    wr(8'h00, 24'h33);
    repeat (10) @(negedge clk);
    seg(1, 10); seg(0, 140);
    expq.push_back(8'h0A); expq.push_back(8'hFF);
    drain("R13 inverted byte", 2);
    rd(8'h20, v); chk("R13 nothing more", v, 0);
    rd(8'h30, v); chk("R6 packet end inverted", v & 2, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule